// File: doc/BRIEF.md
# Register-Mapped Watchdog Timer

This block is a watchdog timer peripheral with a 32-bit register write/read port. Software programs a divide value that turns the input clock into a slow tick, usually one millisecond, and a timeout expressed in ticks. While the watchdog runs, a tick counter advances on each tick. If it reaches the programmed timeout before software restarts it, the block raises a reset request toward the system reset controller for a fixed number of input clocks.

Software keeps the system alive by writing any value to the restart register. It can stop the watchdog by clearing the enable bit with a read-modify-write, which leaves the other control bits intact. It can also force a reset request at once through a self-clearing control bit. The block holds three registers. Control is at offset 0x0, timeout at 0x8 and restart at 0xC. All other offsets are unmapped.

Top module: `wdog_timer`

## Requirements
- R1: After reset, `rst_req_o` is low and the control (0x0) and timeout (0x8) registers read 0.
- R2: The control register at offset 0x0 stores bit 25 (divider on), bit 24 (clock on), bit 21 (reset on expiry), bit 18 (watchdog enable) and bits 17:0 (divide value), and reads them back from the next cycle. All other bits, bit 26 included, read as 0.
- R3: The timeout register at offset 0x8 stores bits 15:0 and reads them back, with bits 31:16 reading 0. Writes to it leave the control register unchanged.
- R4: With bits 25, 24, 18 and 21 all set, a tick occurs every D input clocks, where D is the divide value and a value of 0 acts as 1. The reset request rises exactly D*T clock edges after the control write that starts the watchdog, where T is the timeout. A timeout of 0 behaves like 1 and expires on the first tick.
- R5: A reset request stays high for exactly 16 clocks. Expiry returns the tick count to zero, so the next expiry follows D*T edges after the previous one.
- R6: Writing a 1 to control bit 26 raises `rst_req_o` on the clock edge of that write, whatever the enable bits hold, for 16 clocks. Bit 26 is never stored.
- R7: A write of any data to offset 0xC clears both the divider and tick counts at that edge, even when a tick falls on the same edge. The next expiry then comes a full D*T edges later. The restart register reads 0.
- R8: Clearing the enable bit (bit 18) stops the watchdog and clears its counts, so no reset request occurs while it is stopped. Setting the bit again starts a full D*T period.
- R9: With bit 21 clear, the tick count still wraps at the timeout but no reset request is raised.
- R10: Writes to unmapped offsets such as 0x4 change no register, and reads from them return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock; also the source of the tick |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe, one write per cycle |
| reg_addr_i | input | 4 | Byte offset of the accessed register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| rst_req_o | output | 1 | Reset request to the system reset controller, active high |

## Verification
A divider count that is off by one shows up at the ports as a reset request one edge early or late per tick, so the error grows to T edges by the moment of expiry. For that reason the bench measures the exact edge of the rising edge rather than just whether a rise happens. A tick count that fails to clear on restart, on stop or after expiry shows up as an expiry that arrives early, within one timeout period. A stuck or mis-loaded pulse counter shows up as a request width other than 16, visible as soon as the request falls.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int unsigned REG_W  = 32;
    localparam int unsigned ADDR_W = 4;
    localparam int unsigned DIV_W  = 18;
    localparam int unsigned TMO_W  = 16;

    // register offsets decoded by software
    localparam logic [ADDR_W-1:0] OFS_CTRL = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_TMO  = 4'h8;
    localparam logic [ADDR_W-1:0] OFS_KICK = 4'hC;

    // control bit positions decoded by software
    localparam int unsigned BIT_FIRE   = 26;
    localparam int unsigned BIT_DIV_ON = 25;
    localparam int unsigned BIT_CLK_ON = 24;
    localparam int unsigned BIT_ARM    = 21;
    localparam int unsigned BIT_RUN    = 18;

    typedef struct packed {
        logic             div_on;
        logic             clk_on;
        logic             arm;
        logic             run;
        logic [DIV_W-1:0] div;
    } ctrl_t;

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [REG_W-1:0]  wdata_i,
    output ctrl_t             ctrl_o,
    output logic [TMO_W-1:0]  tmo_o,
    output logic              kick_o,
    output logic              fire_o,
    output logic [REG_W-1:0]  rdata_o
);

    typedef struct packed {
        ctrl_t            ctrl;
        logic [TMO_W-1:0] tmo;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  hit_ctrl, hit_tmo, hit_kick;
    logic  unused_wdata;

    assign unused_wdata = ^wdata_i;

    always_comb begin
        hit_ctrl = we_i && (addr_i == OFS_CTRL);
        hit_tmo  = we_i && (addr_i == OFS_TMO);
        hit_kick = we_i && (addr_i == OFS_KICK);

        regs_d = regs_q;
        if (hit_ctrl) begin
            regs_d.ctrl.div_on = wdata_i[BIT_DIV_ON];
            regs_d.ctrl.clk_on = wdata_i[BIT_CLK_ON];
            regs_d.ctrl.arm    = wdata_i[BIT_ARM];
            regs_d.ctrl.run    = wdata_i[BIT_RUN];
            regs_d.ctrl.div    = wdata_i[DIV_W-1:0];
        end
        if (hit_tmo) begin
            regs_d.tmo = wdata_i[TMO_W-1:0];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    // readback; the force bit and the restart register always read zero
    always_comb begin
        rdata_o = '0;
        case (addr_i)
            OFS_CTRL: begin
                rdata_o[BIT_DIV_ON]  = regs_q.ctrl.div_on;
                rdata_o[BIT_CLK_ON]  = regs_q.ctrl.clk_on;
                rdata_o[BIT_ARM]     = regs_q.ctrl.arm;
                rdata_o[BIT_RUN]     = regs_q.ctrl.run;
                rdata_o[DIV_W-1:0]   = regs_q.ctrl.div;
            end
            OFS_TMO: begin
                rdata_o[TMO_W-1:0] = regs_q.tmo;
            end
            default: begin
                rdata_o = '0;
            end
        endcase
    end

    assign ctrl_o = regs_q.ctrl;
    assign tmo_o  = regs_q.tmo;
    assign kick_o = hit_kick;
    assign fire_o = hit_ctrl && wdata_i[BIT_FIRE];

endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
    parameter int unsigned DIV_W = 18
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             clear_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } pre_t;

    pre_t           pre_d, pre_q;
    logic [DIV_W:0] nxt;
    logic           reached;

    always_comb begin
        nxt     = {1'b0, pre_q.cnt} + {{DIV_W{1'b0}}, 1'b1};
        // a divide value of zero reaches on every clock, like one
        reached = nxt >= {1'b0, div_i};
        tick_o  = run_i && !clear_i && reached;

        pre_d = pre_q;
        if (!run_i || clear_i || reached) begin
            pre_d.cnt = '0;
        end else begin
            pre_d.cnt = nxt[DIV_W-1:0];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_d;
        end
    end

endmodule

// File: rtl/wdog_tick_ctr.sv
module wdog_tick_ctr #(
    parameter int unsigned TMO_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             clear_i,
    input  logic             tick_i,
    input  logic             arm_i,
    input  logic [TMO_W-1:0] tmo_i,
    output logic             expire_o,
    output logic [TMO_W-1:0] count_o
);

    typedef struct packed {
        logic [TMO_W-1:0] cnt;
    } tck_t;

    tck_t           tck_d, tck_q;
    logic [TMO_W:0] nxt;
    logic           reached;

    always_comb begin
        nxt      = {1'b0, tck_q.cnt} + {{TMO_W{1'b0}}, 1'b1};
        // ">=" also covers a timeout lowered below the running count
        reached  = nxt >= {1'b0, tmo_i};
        expire_o = tick_i && reached && arm_i;

        tck_d = tck_q;
        if (!run_i || clear_i) begin
            tck_d.cnt = '0;
        end else if (tick_i) begin
            tck_d.cnt = reached ? '0 : nxt[TMO_W-1:0];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tck_q <= '0;
        end else begin
            tck_q <= tck_d;
        end
    end

    assign count_o = tck_q.cnt;

endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
    parameter int unsigned PULSE_LEN = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    output logic req_o
);

    localparam int unsigned CW = $clog2(PULSE_LEN + 1);

    typedef struct packed {
        logic [CW-1:0] left;
    } pls_t;

    pls_t pls_d, pls_q;

    always_comb begin
        pls_d = pls_q;
        if (start_i) begin
            pls_d.left = CW'(PULSE_LEN);
        end else if (pls_q.left != '0) begin
            pls_d.left = pls_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pls_q <= '0;
        end else begin
            pls_q <= pls_d;
        end
    end

    assign req_o = pls_q.left != '0;

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int unsigned PULSE_LEN = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              reg_we_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [REG_W-1:0]  reg_wdata_i,
    output logic [REG_W-1:0]  reg_rdata_o,
    output logic              rst_req_o
);

    ctrl_t            ctrl;
    logic [TMO_W-1:0] tmo;
    logic             kick, fire, running, tick, expire;
    logic [TMO_W-1:0] tick_cnt;

    wdog_regs i_regs (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (reg_we_i),
        .addr_i  (reg_addr_i),
        .wdata_i (reg_wdata_i),
        .ctrl_o  (ctrl),
        .tmo_o   (tmo),
        .kick_o  (kick),
        .fire_o  (fire),
        .rdata_o (reg_rdata_o)
    );

    assign running = ctrl.run && ctrl.clk_on && ctrl.div_on;

    wdog_prescaler #(.DIV_W(DIV_W)) i_pre (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .run_i   (running),
        .clear_i (kick),
        .div_i   (ctrl.div),
        .tick_o  (tick)
    );

    wdog_tick_ctr #(.TMO_W(TMO_W)) i_tck (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .run_i    (running),
        .clear_i  (kick),
        .tick_i   (tick),
        .arm_i    (ctrl.arm),
        .tmo_i    (tmo),
        .expire_o (expire),
        .count_o  (tick_cnt)
    );

    wdog_pulse #(.PULSE_LEN(PULSE_LEN)) i_pls (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (expire || fire),
        .req_o   (rst_req_o)
    );

endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk
    import wdog_pkg::*;
#(
    parameter int unsigned PULSE_LEN = 16
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              we_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [REG_W-1:0]  wdata_i,
    input logic [REG_W-1:0]  rdata_i,
    input logic              req_i,
    input logic              run_i,
    input logic              arm_i,
    input logic [TMO_W-1:0]  cnt_i,
    input logic [TMO_W-1:0]  tmo_i
);

    logic [31:0] hi_cnt;
    logic        fire_wr;

    assign fire_wr = we_i && (addr_i == OFS_CTRL) && wdata_i[BIT_FIRE];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            hi_cnt <= '0;
        end else if (req_i) begin
            hi_cnt <= (hi_cnt == 32'hFFFF_FFFF) ? hi_cnt : hi_cnt + 1;
        end else begin
            hi_cnt <= '0;
        end
    end

    p_tmo_store_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && addr_i == OFS_TMO) |=> (tmo_i == $past(wdata_i[TMO_W-1:0])));

    p_pulse_len_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(req_i) |-> (hi_cnt >= PULSE_LEN));

    p_fire_next_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fire_wr |=> req_i);

    p_kick_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && addr_i == OFS_KICK) |=> (cnt_i == '0));

    p_kick_reads_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (addr_i == OFS_KICK) |-> (rdata_i == '0));

    p_stop_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> (cnt_i == '0));

    p_rise_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(req_i) |-> $past(fire_wr || (run_i && arm_i)));

endmodule

bind wdog_timer wdog_timer_chk #(.PULSE_LEN(PULSE_LEN)) i_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_i (reg_rdata_o),
    .req_i   (rst_req_o),
    .run_i   (running),
    .arm_i   (ctrl.arm),
    .cnt_i   (tick_cnt),
    .tmo_i   (tmo)
);

// File: tb/test_wdog_timer.sv
module test_wdog_timer;

    localparam int CLK_PERIOD = 10;
    localparam logic [3:0] A_CTRL = 4'h0;
    localparam logic [3:0] A_TMO  = 4'h8;
    localparam logic [3:0] A_KICK = 4'hC;
    localparam logic [3:0] A_HOLE = 4'h4;
    localparam int PULSE = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rst_req;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdog_timer i_wdog_timer (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .reg_we_i    (we),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .rst_req_o   (rst_req)
    );

    function automatic logic [31:0] mk(input bit run, input bit clk_on, input bit div_on,
                                       input bit arm, input bit fire, input logic [17:0] d);
        logic [31:0] v;
        v = '0;
        v[26] = fire; v[25] = div_on; v[24] = clk_on; v[21] = arm; v[18] = run;
        v[17:0] = d;
        return v;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        we = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        we = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic wait_rise(input int limit, output int n);
        n = 0;
        while (!rst_req && n < limit) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic width(output int w);
        w = 0;
        while (rst_req && w < 1000) begin
            w++;
            @(negedge clk);
        end
    endtask

    task automatic quiesce();
        wr(A_CTRL, '0);
        while (rst_req) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk(rst_req == 1'b0, "R1 request low after reset", rst_req, 0);
        rd(A_CTRL, v); chk(v == 0, "R1 control after reset", v, 0);
        rd(A_TMO, v);  chk(v == 0, "R1 timeout after reset", v, 0);
    endtask

    task automatic t_readback();
        logic [31:0] v;
        wr(A_CTRL, 32'hFBFF_FFFF);
        rd(A_CTRL, v); chk(v == 32'h0327_FFFF, "R2 control readback", v, 32'h0327_FFFF);
        wr(A_TMO, 32'hDEAD_BEEF);
        rd(A_TMO, v);  chk(v == 32'h0000_BEEF, "R3 timeout readback", v, 32'h0000_BEEF);
        rd(A_CTRL, v); chk(v == 32'h0327_FFFF, "R3 control kept", v, 32'h0327_FFFF);
        wr(A_CTRL, '0);
        rd(A_CTRL, v); chk(v == 0, "R2 control cleared", v, 0);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        wr(A_HOLE, 32'hFFFF_FFFF);
        rd(A_HOLE, v); chk(v == 0, "R10 unmapped read", v, 0);
        rd(A_CTRL, v); chk(v == 0, "R10 control untouched", v, 0);
        rd(A_TMO, v);  chk(v == 32'hBEEF, "R10 timeout untouched", v, 32'hBEEF);
        chk(rst_req == 1'b0, "R10 no request", rst_req, 0);
        wr(A_KICK, 32'h1234_5678);
        rd(A_KICK, v); chk(v == 0, "R7 restart reads zero", v, 0);
    endtask

    task automatic t_expire();
        int n, w;
        wr(A_TMO, 4);
        wr(A_CTRL, mk(1, 1, 1, 1, 0, 5));
        wait_rise(100, n); chk(n == 20, "R4 expiry edge D5 T4", n, 20);
        width(w);          chk(w == PULSE, "R5 pulse width", w, PULSE);
        wait_rise(100, n); chk(n == 4, "R5 next expiry after count reset", n, 4);
        quiesce();
    endtask

    task automatic t_corner();
        int n;
        wr(A_TMO, 0);
        wr(A_CTRL, mk(1, 1, 1, 1, 0, 3));
        wait_rise(100, n); chk(n == 3, "R4 timeout zero first tick", n, 3);
        quiesce();
        wr(A_TMO, 2);
        wr(A_CTRL, mk(1, 1, 1, 1, 0, 0));
        wait_rise(100, n); chk(n == 2, "R4 divide zero acts as one", n, 2);
        quiesce();
    endtask

    task automatic t_kick();
        int n;
        wr(A_TMO, 5);
        wr(A_CTRL, mk(1, 1, 1, 1, 0, 4));
        repeat (11) @(negedge clk);
        chk(rst_req == 1'b0, "R7 no request before restart", rst_req, 0);
        wr(A_KICK, 32'hA5A5_A5A5);
        wait_rise(100, n); chk(n == 20, "R7 full period after restart on tick", n, 20);
        quiesce();
    endtask

    task automatic t_stop();
        int n;
        logic [31:0] v;
        wr(A_TMO, 3);
        wr(A_CTRL, mk(1, 1, 1, 1, 0, 2));
        repeat (3) @(negedge clk);
        wr(A_CTRL, mk(0, 1, 1, 1, 0, 2));
        rd(A_CTRL, v); chk(v == mk(0, 1, 1, 1, 0, 2), "R8 other bits kept on stop", v, mk(0, 1, 1, 1, 0, 2));
        wait_rise(40, n); chk(rst_req == 1'b0, "R8 no request while stopped", rst_req, 0);
        wr(A_CTRL, mk(1, 1, 1, 1, 0, 2));
        wait_rise(100, n); chk(n == 6, "R8 full period after restart of enable", n, 6);
        quiesce();
    endtask

    task automatic t_noarm();
        int n;
        wr(A_TMO, 2);
        wr(A_CTRL, mk(1, 1, 1, 0, 0, 2));
        wait_rise(30, n); chk(rst_req == 1'b0, "R9 no request without reset-on-expiry", rst_req, 0);
        quiesce();
    endtask

    task automatic t_fire();
        int w;
        logic [31:0] v;
        wr(A_CTRL, mk(0, 0, 0, 0, 1, 0));
        chk(rst_req == 1'b1, "R6 forced request at write edge", rst_req, 1);
        rd(A_CTRL, v); chk(v == 0, "R6 force bit reads zero", v, 0);
        width(w); chk(w == PULSE, "R6 forced pulse width", w, PULSE);
        quiesce();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_readback();
        t_unmapped();
        t_expire();
        t_corner();
        t_kick();
        t_stop();
        t_noarm();
        t_fire();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule